// File: doc/BRIEF.md
# Tapped-Delay Matched Bit Detector

This block recovers binary data from a baseband sample stream. Each bit period holds a fixed number of signed samples. The block keeps the most recent bit period's worth of samples in a tapped delay line and tracks their sum. That sum is a moving-window integrate that rises in stair steps.

An external bit synchronizer supplies a strobe at the end of every bit period. On that strobe the block takes the window sum and slices it to a hard bit. It holds that bit until the next strobe and flags the update with a one-cycle valid pulse. Bit timing recovery is left to the synchronizer.

One sample enters per clock. The sum is updated incrementally: the newest sample is added and the sample that leaves the window is subtracted. Between strobes the window keeps sliding, so the strobe alone decides which K samples form a decision.

Top module: `mf_bit_detector`

## Requirements
- R1: An active-low asynchronous reset clears the delay line, the window sum, `bit_o` and `bit_vld_o`. After reset the window therefore reads as K zero samples.
- R2: The window on which a decision is made is the K most recent samples, where K = `SPB`. It includes the sample presented in the strobe cycle.
- R3: The decision is 1 when the window sum, read as a two's-complement value, is zero or positive. It is 0 when the sum is negative, so a sum of exactly zero gives 1.
- R4: `bit_vld_o` is high for exactly the one cycle after each clock edge at which `strobe_i` is high, and low otherwise.
- R5: `bit_o` changes only on the edge that follows a strobe. Between strobes it holds the last decision.
- R6: The window sum does not wrap for any input. K samples all at the most negative code give 0, and K samples all at the most positive code give 1.
- R7: Strobes on consecutive clock cycles each produce a decision on the window that has slid by one sample.
- R8: A sample older than K samples has no effect on a decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one sample per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | SAMPLE_W | Signed two's-complement input sample |
| strobe_i | input | 1 | End-of-bit strobe from the bit synchronizer |
| bit_o | output | 1 | Held recovered bit |
| bit_vld_o | output | 1 | One-cycle pulse on each new decision |

## Verification
The bench builds the block with `SPB` = 5 and `SAMPLE_W` = 4. Five is not a power of two, so it exercises the derived sum width where that width is not an exact fit. Full-scale windows of +35 and -40 fit in a few cycles, which makes the edges of the sum range easy to reach. A run of five most-negative samples followed by small positive ones shows that old samples leave the window, and hand-picked windows land exactly on a sum of zero.

// File: rtl/mf_pkg.sv
package mf_pkg;
  // Width needed to hold the sum of k signed w-bit samples
  function automatic int sum_width(int w, int k);
    return w + $clog2(k);
  endfunction
endpackage

// File: rtl/mf_tap_line.sv
module mf_tap_line #(
  parameter int W = 8,
  parameter int K = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   smp_i,
  output logic [K*W-1:0] taps_o,
  output logic [W-1:0]   oldest_o
);
  for (genvar i = 0; i < K; i++) begin : g_stg
    logic [W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= smp_i;
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= g_stg[i-1].q;
    end
    assign taps_o[i*W +: W] = q;
  end

  assign oldest_o = taps_o[(K-1)*W +: W];
endmodule

// File: rtl/mf_run_sum.sv
module mf_run_sum #(
  parameter int W  = 8,
  parameter int SW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  smp_i,
  input  logic [W-1:0]  oldest_i,
  output logic [SW-1:0] sum_o,
  output logic [SW-1:0] sum_nxt_o
);
  logic [SW-1:0] new_ext, old_ext, sum_q;

  assign new_ext   = {{(SW-W){smp_i[W-1]}}, smp_i};
  assign old_ext   = {{(SW-W){oldest_i[W-1]}}, oldest_i};
  assign sum_nxt_o = sum_q + new_ext - old_ext;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= sum_nxt_o;

  assign sum_o = sum_q;
endmodule

// File: rtl/mf_slicer.sv
module mf_slicer #(
  parameter int SW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  input  logic [SW-1:0] sum_nxt_i,
  output logic          bit_o,
  output logic          bit_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= strobe_i;
      if (strobe_i) bit_o <= ~sum_nxt_i[SW-1];  // zero or positive -> 1
    end
  end
endmodule

// File: rtl/mf_bit_detector.sv
module mf_bit_detector #(
  parameter int SAMPLE_W = 8,
  parameter int SPB      = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                strobe_i,
  output logic                bit_o,
  output logic                bit_vld_o
);
  localparam int SUM_W = mf_pkg::sum_width(SAMPLE_W, SPB);

  logic [SPB*SAMPLE_W-1:0] taps;
  logic [SAMPLE_W-1:0]     oldest;
  logic [SUM_W-1:0]        sum_q, sum_nxt;

  mf_tap_line #(.W(SAMPLE_W), .K(SPB)) u_taps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (sample_i),
    .taps_o  (taps),
    .oldest_o(oldest)
  );

  mf_run_sum #(.W(SAMPLE_W), .SW(SUM_W)) u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_i    (sample_i),
    .oldest_i (oldest),
    .sum_o    (sum_q),
    .sum_nxt_o(sum_nxt)
  );

  mf_slicer #(.SW(SUM_W)) u_slice (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .sum_nxt_i(sum_nxt),
    .bit_o    (bit_o),
    .bit_vld_o(bit_vld_o)
  );
endmodule

// File: rtl/mf_bit_detector_chk.sv
module mf_bit_detector_chk #(
  parameter int SAMPLE_W = 8,
  parameter int SPB      = 8,
  parameter int SUM_W    = 11
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    strobe_i,
  input logic                    bit_o,
  input logic                    bit_vld_o,
  input logic [SUM_W-1:0]        sum_q,
  input logic [SPB*SAMPLE_W-1:0] taps
);
  logic signed [SUM_W-1:0] tap_total;

  always_comb begin
    tap_total = '0;
    for (int i = 0; i < SPB; i++)
      tap_total = tap_total + SUM_W'($signed(taps[i*SAMPLE_W +: SAMPLE_W]));
  end

  // R2 R6 R8: running total equals the full sum of the K held taps
  assert_sum_is_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(sum_q) == tap_total);

  assert_decision_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (bit_o == ($signed(sum_q) >= 0)));

  assert_vld_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> bit_vld_o);

  assert_vld_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !bit_vld_o);

  assert_bit_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(bit_o));
endmodule

bind mf_bit_detector mf_bit_detector_chk #(
  .SAMPLE_W(SAMPLE_W), .SPB(SPB), .SUM_W(SUM_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .bit_o    (bit_o),
  .bit_vld_o(bit_vld_o),
  .sum_q    (sum_q),
  .taps     (taps)
);

// File: tb/test_mf_bit_detector.sv
`timescale 1ns/1ps
module test_mf_bit_detector;
  localparam int W = 4;
  localparam int K = 5;
  localparam int SMAX = (1 << (W-1)) - 1;
  localparam int SMIN = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst_ni = 1'b1;
  logic [W-1:0] sample_i = '0;
  logic         strobe_i = 1'b0;
  logic         bit_o, bit_vld_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int win[$];
  bit exp_bit = 1'b0, exp_vld = 1'b0;

  always #10 clk = ~clk;

  mf_bit_detector #(.SAMPLE_W(W), .SPB(K)) i_mf_bit_detector (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .strobe_i(strobe_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );

  function automatic int win_sum();
    int s = 0;
    foreach (win[i]) s += win[i];
    return s;
  endfunction

  task automatic check(string req, bit act_b, bit exp_b, bit act_v, bit exp_v);
    checks++;
    if (act_b !== exp_b) begin
      errors++;
      $display("FAIL %s bit_o act=%0b exp=%0b t=%0t", req, act_b, exp_b, $time);
    end
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL R4 bit_vld_o act=%0b exp=%0b t=%0t", act_v, exp_v, $time);
    end
  endtask

  // One clock: drive, model, compare after the edge
  task automatic step(int smp, bit stb, string req);
    @(negedge clk);
    sample_i = W'(smp);
    strobe_i = stb;
    @(posedge clk);
    #1;
    win.push_front(smp);
    if (win.size() > K) void'(win.pop_back());
    if (stb) exp_bit = (win_sum() >= 0);
    exp_vld = stb;
    check(stb ? req : "R5", bit_o, exp_bit, bit_vld_o, exp_vld);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", bit_o, 1'b0, bit_vld_o, 1'b0);  // R1 outputs cleared in reset
    @(negedge clk);
    rst_ni = 1'b1;
    win.delete();
    for (int i = 0; i < K; i++) win.push_back(0);
    exp_bit = 1'b0; exp_vld = 1'b0;

    // R1: empty window plus zero sample sums to 0 -> 1
    step(0, 1'b1, "R1");

    // R3: exact zero sum gives 1, sum of -1 gives 0
    step(3, 0, "R3"); step(-3, 0, "R3"); step(2, 0, "R3"); step(-2, 0, "R3");
    step(0, 1'b1, "R3");
    step(1, 0, "R3"); step(1, 0, "R3"); step(1, 0, "R3"); step(1, 0, "R3");
    step(-5, 1'b1, "R3");

    // R6: full-scale windows
    for (int i = 0; i < K; i++) step(SMAX, i == K-1, "R6");
    for (int i = 0; i < K; i++) step(SMIN, i == K-1, "R6");

    // R8: old negative samples drop out of the window
    for (int i = 0; i < K; i++) step(SMIN, 0, "R8");
    for (int i = 0; i < K; i++) step(1, i == K-1, "R8");

    // R2 R5: periodic strobes over random samples
    for (int b = 0; b < 60; b++)
      for (int i = 0; i < K; i++)
        step(int'($urandom_range(0, 15)) - 8, i == K-1, "R2");

    // R7: back-to-back strobes on a sliding window
    for (int i = 0; i < 30; i++)
      step(int'($urandom_range(0, 15)) - 8, 1'b1, "R7");
    for (int i = 0; i < 8; i++) step((i % 2) ? 7 : -7, 1'b1, "R7");
    step(0, 0, "R5");
    step(0, 0, "R5");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule